// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Controller

This block serves a simple on-chip read port (valid, address, ready, data) from an external serial flash. Each byte read becomes a single-lane serial read frame. The frame starts with the read opcode and a 24-bit address, and one data byte follows with no wait bits between address and data. After a byte is returned the controller keeps chip select low. A read at the next address then only clocks eight more data bits, without resending the opcode or address.

An optional idle timeout releases chip select after a programmed number of idle cycles so the flash can drop into low power. When the timeout fires it sets a sticky flag, which a clear pulse resets. A new read may arrive on the very clock edge at which the timeout expires. In that case the controller releases chip select, sets the flag, waits out the minimum deselect time and serves the read with a fresh frame. It never stalls.

An abort pulse ends any frame, releases chip select and drops memory-mapped mode. A busy indication stays high until the deselect time has been honoured. A separate pulse re-enters memory-mapped mode.

Top module: `sflash_mmap_rd`

## Requirements
- R1: A read frame drives chip select low and shifts out 32 bits MSB first on MOSI: opcode 0x03, then the 24-bit address. It then samples 8 data bits from MISO, MSB first, with no wait bits. SCLK idles low and each bit takes two controller clocks: MOSI changes while SCLK is low, and MISO is sampled as SCLK rises.
- R2: A served read returns its byte with `rd_ready` high for exactly one cycle and `rd_err` low.
- R3: A read whose address is the previous address plus one, arriving while chip select is still low, adds only 8 SCLK data bits and starts no new frame.
- R4: A read to any other address while chip select is low releases chip select, waits out the deselect time and issues a new frame carrying the new address.
- R5: With `to_en` high, chip select stays low after a read for `to_count` clock cycles, counted from the cycle in which `rd_ready` is high. It goes high in the next cycle, and `to_flag` is set in that same cycle. With `to_en` low, chip select stays low indefinitely.
- R6: A read that arrives on the same edge as the timeout expiry does not stall. Chip select is released, `to_flag` is set, and the read is served with a fresh frame and correct data.
- R7: Between frames, chip select stays high for at least 2*(`cs_gap`+1) controller clocks.
- R8: An address at or above 2^(`size_code`+1) gets `rd_ready` with `rd_err` high and `rd_data` zero. It starts no frame.
- R9: An abort releases chip select and clears `mm_active` on the next edge. A read in flight completes with `rd_err` high. `abort_busy` is high from that edge until the deselect time is over, and then it clears. Later reads get an error until `mm_enter` is pulsed.
- R10: A one-cycle pulse on `to_clr` clears `to_flag` on the next edge.
- R11: After reset: `spi_cs_n` high, `spi_sclk` low, `rd_ready` low, `mm_active` low, `abort_busy` low and `to_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 24 | Byte address of the request |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Returned byte |
| rd_err | output | 1 | Request rejected or aborted |
| mm_enter | input | 1 | Pulse: enter memory-mapped mode |
| abort_req | input | 1 | Pulse: abort and leave memory-mapped mode |
| abort_busy | output | 1 | Abort still completing |
| mm_active | output | 1 | Memory-mapped mode on |
| to_en | input | 1 | Idle timeout enable |
| to_count | input | 16 | Idle cycles before release |
| to_flag | output | 1 | Sticky timeout flag |
| to_clr | input | 1 | Pulse: clear the timeout flag |
| cs_gap | input | 3 | Deselect time code |
| size_code | input | 5 | Flash size code, 2^(code+1) bytes |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions rely on the following input discipline:
- The requester holds `rd_valid` and `rd_addr` steady until `rd_ready`.
- `abort_req` and `to_clr` are single-cycle pulses.
- `cs_gap`, `size_code` and `to_count` change only while no frame is in progress. The deselect-time check needs `cs_gap` to be stable.

The bench stays within these rules:
- Its read task raises a request only between completions and drops it in the cycle it observes `rd_ready`.
- Configuration changes are made at quiet points.
- The expiry collision is created on purpose by issuing the sequential read exactly `to_count` cycles after a completion. The same read one cycle earlier is used as the contrasting case.

// File: rtl/sfr_pkg.sv
// Shared types for the serial flash read controller.
// Assumes single-lane framing with an 8-bit opcode.
package sfr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // chip select high, deselect time met
        ST_GAP,   // chip select high, deselect time running
        ST_CMD,   // shifting opcode and address
        ST_DATA,  // shifting one data byte
        ST_HOLD   // chip select held low between bytes
    } sfr_state_e;

    localparam logic [7:0] RD_OPCODE = 8'h03;
endpackage

// File: rtl/sfr_shifter.sv
// Bit engine: shifts nbits out on MOSI (MSB first) while capturing MISO.
// Each bit takes two clocks: SCLK low then SCLK high. MISO is captured at
// the rising step, and done pulses once SCLK has returned low after the
// last bit. Assumes start is raised only while idle.
module sfr_shifter #(
    parameter int TX_W  = 32,
    parameter int RX_W  = 8,
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              start,
    input  logic [TX_W-1:0]   load_tx,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [RX_W-1:0]   rx
);
    logic             busy;
    logic             ph;
    logic [CNT_W-1:0] cnt;
    logic [TX_W-1:0]  tx;

    assign mosi = tx[TX_W-1];

    // Purpose: step the serial clock and the shift registers one half-bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ph   <= 1'b0;
            sclk <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            tx   <= '0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            if (kill) begin
                busy <= 1'b0;
                ph   <= 1'b0;
                sclk <= 1'b0;
            end else if (start) begin
                busy <= 1'b1;
                ph   <= 1'b0;
                sclk <= 1'b0;
                cnt  <= nbits;
                tx   <= load_tx;
            end else if (busy) begin
                if (!ph) begin
                    sclk <= 1'b1;
                    ph   <= 1'b1;
                    rx   <= {rx[RX_W-2:0], miso};
                    cnt  <= cnt - 1'b1;
                end else begin
                    sclk <= 1'b0;
                    ph   <= 1'b0;
                    tx   <= tx << 1;
                    if (cnt == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    // R1: the data line never moves while the serial clock is high
    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
endmodule

// File: rtl/sfr_idle_timer.sv
// Idle timeout counter: counts clocks while run is high and flags expiry
// in the cycle in which the count reaches limit. Clears whenever run drops.
module sfr_idle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

    // Purpose: count idle cycles, restarting whenever the hold period ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (!expire)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfr_gap_timer.sv
// Deselect timer: after restart, done rises once 2*(code+1) clocks have
// passed. Comes out of reset already done.
module sfr_gap_timer #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [GAP_W-1:0] code,
    output logic             done
);
    localparam int CW = GAP_W + 2;
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    assign target = ({2'b00, code} + 1'b1) << 1;
    assign done   = (cnt >= target);

    // Purpose: measure chip-select high time from the release edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (restart)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sflash_mmap_rd.sv
// Memory-mapped serial flash read controller (top).
// Turns byte reads into single-lane read frames. It keeps chip select low
// between sequential bytes and releases it on idle timeout, on a
// non-sequential address or on abort. Assumes rd_valid and rd_addr are held
// until rd_ready, and that the configuration inputs are stable during frames.
module sflash_mmap_rd
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int TO_W   = 16,
    parameter int GAP_W  = 3,
    parameter int SZ_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    input  logic              mm_enter,
    input  logic              abort_req,
    output logic              abort_busy,
    output logic              mm_active,
    input  logic              to_en,
    input  logic [TO_W-1:0]   to_count,
    output logic              to_flag,
    input  logic              to_clr,
    input  logic [GAP_W-1:0]  cs_gap,
    input  logic [SZ_W-1:0]   size_code,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int CMD_W = 8 + ADDR_W;
    localparam int CNT_W = $clog2(CMD_W + 1);

    sfr_state_e        st;
    logic              mm_on;
    logic [ADDR_W-1:0] next_addr;
    logic              sh_start, sh_done;
    logic [CMD_W-1:0]  sh_load;
    logic [CNT_W-1:0]  sh_nbits;
    logic [DATA_W-1:0] sh_rx;
    logic              expire, gap_done, go_gap;
    logic              take, in_range;
    logic [SZ_W:0]     sz_shift;

    assign mm_active = mm_on;
    assign take      = rd_valid && !rd_ready;
    assign sz_shift  = {1'b0, size_code} + 1'b1;
    assign in_range  = ((rd_addr >> sz_shift) == '0);
    assign go_gap    = abort_req || ((st == ST_HOLD) &&
                       (expire || (take && in_range && (rd_addr != next_addr))));

    sfr_shifter #(.TX_W(CMD_W), .RX_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .kill(abort_req), .start(sh_start),
        .load_tx(sh_load), .nbits(sh_nbits), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx));

    sfr_idle_timer #(.CW(TO_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .run((st == ST_HOLD) && to_en),
        .limit(to_count), .expire(expire));

    sfr_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .restart(go_gap), .code(cs_gap),
        .done(gap_done));

    // Purpose: decide when the bit engine starts and what it shifts.
    always_comb begin
        sh_start = 1'b0;
        sh_load  = '0;
        sh_nbits = CNT_W'(DATA_W);
        if (!abort_req) begin
            case (st)
                ST_IDLE: if (take && mm_on && in_range) begin
                    sh_start = 1'b1;
                    sh_load  = {RD_OPCODE, rd_addr};
                    sh_nbits = CNT_W'(CMD_W);
                end
                ST_CMD:  sh_start = sh_done;
                ST_HOLD: sh_start = take && in_range && !go_gap;
                default: sh_start = 1'b0;
            endcase
        end
    end

    // Purpose: frame sequencing, bus responses, mode and flag bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            mm_on      <= 1'b0;
            spi_cs_n   <= 1'b1;
            rd_ready   <= 1'b0;
            rd_err     <= 1'b0;
            rd_data    <= '0;
            next_addr  <= '0;
            to_flag    <= 1'b0;
            abort_busy <= 1'b0;
        end else begin
            rd_ready <= 1'b0;
            rd_err   <= 1'b0;
            if (to_clr)   to_flag <= 1'b0;
            if (mm_enter) mm_on   <= 1'b1;
            if (st == ST_HOLD && expire) to_flag <= 1'b1;
            if (abort_req) begin
                st         <= ST_GAP;
                spi_cs_n   <= 1'b1;
                mm_on      <= 1'b0;
                abort_busy <= 1'b1;
                if (st == ST_CMD || st == ST_DATA) begin
                    rd_ready <= 1'b1;
                    rd_err   <= 1'b1;
                    rd_data  <= '0;
                end
            end else begin
                case (st)
                    ST_IDLE: if (take) begin
                        if (mm_on && in_range) begin
                            spi_cs_n  <= 1'b0;
                            st        <= ST_CMD;
                            next_addr <= rd_addr + 1'b1;
                        end else begin
                            rd_ready <= 1'b1;
                            rd_err   <= 1'b1;
                            rd_data  <= '0;
                        end
                    end
                    ST_CMD:  if (sh_done) st <= ST_DATA;
                    ST_DATA: if (sh_done) begin
                        rd_ready <= 1'b1;
                        rd_data  <= sh_rx;
                        st       <= ST_HOLD;
                    end
                    ST_HOLD: if (go_gap) begin
                        spi_cs_n <= 1'b1;
                        st       <= ST_GAP;
                    end else if (take) begin
                        if (in_range) begin
                            st        <= ST_DATA;
                            next_addr <= next_addr + 1'b1;
                        end else begin
                            rd_ready <= 1'b1;
                            rd_err   <= 1'b1;
                            rd_data  <= '0;
                        end
                    end
                    ST_GAP: if (gap_done) begin
                        st         <= ST_IDLE;
                        abort_busy <= 1'b0;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Checker state: length of the current chip-select high run.
    logic [7:0]       hi_run;
    logic             seen_low;
    logic [GAP_W+1:0] gap_min;
    assign gap_min = ({2'b00, cs_gap} + 1'b1) << 1;

    // Purpose: track the chip-select high run for the deselect-time check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run   <= '0;
            seen_low <= 1'b0;
        end else begin
            if (!spi_cs_n) seen_low <= 1'b1;
            if (!spi_cs_n)           hi_run <= '0;
            else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
        end
    end

    // R2: completion is a single-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);
    // R1: the serial clock only toggles inside a frame
    p_sclk_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);
    // R5: the timeout flag rises together with a released chip select
    p_flag_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> spi_cs_n);
    // R6: a read colliding with expiry releases chip select rather than stalling
    p_collide_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && expire && take && !abort_req) |=> (spi_cs_n && st == ST_GAP));
    // R7: minimum chip-select high time between frames
    p_cs_high_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && seen_low) |-> (hi_run >= 8'(gap_min)));
    // R9: abort releases the flash and leaves memory-mapped mode
    p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (spi_cs_n && abort_busy && !mm_active));
endmodule

// File: tb/tb_sflash_mmap_rd.sv
// Scoreboard bench with a behavioural serial flash model.
module tb_sflash_mmap_rd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_ready, rd_err;
    logic [7:0]  rd_data;
    logic        mm_enter = 1'b0, abort_req = 1'b0, to_en = 1'b0, to_clr = 1'b0;
    logic        abort_busy, mm_active, to_flag;
    logic [15:0] to_count = 16'd20;
    logic [2:0]  cs_gap = 3'd3;
    logic [4:0]  size_code = 5'd23;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int errors = 0, checks = 0, cyc = 0;
    localparam int TO = 20;

    always #10 clk = ~clk;  // 50 MHz

    sflash_mmap_rd dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
        .mm_enter(mm_enter), .abort_req(abort_req), .abort_busy(abort_busy),
        .mm_active(mm_active), .to_en(to_en), .to_count(to_count),
        .to_flag(to_flag), .to_clr(to_clr), .cs_gap(cs_gap),
        .size_code(size_code), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model: mode 0, opcode plus 24-bit address, then streamed bytes.
    int          fl_bits = 0, cmd_cnt = 0;
    logic [31:0] fl_cmd = '0;
    logic [7:0]  last_op = '0;
    logic [23:0] last_addr = '0;

    always @(negedge spi_cs_n) begin
        fl_bits = 0;
        cmd_cnt++;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (fl_bits < 32) fl_cmd = {fl_cmd[30:0], spi_mosi};
        fl_bits++;
        if (fl_bits == 32) begin
            last_op   = fl_cmd[31:24];
            last_addr = fl_cmd[23:0];
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n && fl_bits >= 32) begin
        logic [7:0] b;
        b = mem_byte(last_addr + 24'((fl_bits - 32) / 8));
        spi_miso <= b[7 - ((fl_bits - 32) % 8)];
    end

    // Scoreboard: driver pushes {err, data}, monitor pops on each completion.
    logic [8:0] sb_q[$];
    string      sb_req[$];

    always @(negedge clk) if (rst_n && rd_ready) begin
        if (sb_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected completion", {23'd0, rd_err, rd_data}, 0);
        end else begin
            logic [8:0] e;
            string r;
            e = sb_q.pop_front();
            r = sb_req.pop_front();
            chk({rd_err, rd_data} == e, r, "read response", {23'd0, rd_err, rd_data}, e);
        end
    end

    // Deselect-time monitor for R7.
    int  hi_cnt = 0;
    bit  had_frame = 0;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n) hi_cnt++;
        else begin
            if (hi_cnt > 0 && had_frame)
                chk(hi_cnt >= 2 * (cs_gap + 1), "R7", "cs high cycles", hi_cnt, 2 * (cs_gap + 1));
            if (hi_cnt > 0) had_frame = 1;
            hi_cnt = 0;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    // Driver: called at a negedge; returns at the negedge where rd_ready is seen.
    task automatic do_read(input logic [23:0] a, input bit exp_err, input string req);
        int n = 0;
        sb_q.push_back(exp_err ? 9'h100 : {1'b0, mem_byte(a)});
        sb_req.push_back(req);
        rd_addr  = a;
        rd_valid = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!rd_ready && n < 5000);
        rd_valid = 1'b0;
        if (n >= 5000) chk(1'b0, req, "read never completed", n, 0);
    endtask

    task automatic pulse_mm();
        mm_enter = 1'b1;
        @(negedge clk);
        mm_enter = 1'b0;
    endtask

    task automatic clear_flag();
        to_clr = 1'b1;
        @(negedge clk);
        to_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(spi_cs_n == 1'b1, "R11", "cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R11", "sclk", spi_sclk, 0);
        chk(rd_ready == 1'b0, "R11", "ready", rd_ready, 0);
        chk({mm_active, abort_busy, to_flag} == 3'b000, "R11", "mode/busy/flag",
            {mm_active, abort_busy, to_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_mm();

        // R1 R2: first read issues a full frame
        c0 = cmd_cnt;
        do_read(24'h001234, 1'b0, "R2");
        chk(cmd_cnt - c0 == 1, "R1", "frames started", cmd_cnt - c0, 1);
        chk(last_op == 8'h03, "R1", "opcode", last_op, 8'h03);
        chk(last_addr == 24'h001234, "R1", "frame address", last_addr, 24'h001234);

        // R3: sequential read continues the frame
        c0 = cmd_cnt;
        do_read(24'h001235, 1'b0, "R3");
        chk(cmd_cnt == c0, "R3", "no new frame", cmd_cnt - c0, 0);
        // R5: timeout disabled keeps cs low
        repeat (60) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R5", "cs held with timeout off", spi_cs_n, 0);

        // R4: non-sequential read restarts
        c0 = cmd_cnt;
        do_read(24'h00ABCD, 1'b0, "R4");
        chk(cmd_cnt - c0 == 1, "R4", "new frame", cmd_cnt - c0, 1);
        chk(last_addr == 24'h00ABCD, "R4", "frame address", last_addr, 24'h00ABCD);

        // R5: timeout releases after to_count cycles
        to_en = 1'b1;
        do_read(24'h00ABCE, 1'b0, "R3");
        repeat (TO - 1) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R5", "cs before expiry", spi_cs_n, 0);
        chk(to_flag == 1'b0, "R5", "flag before expiry", to_flag, 0);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R5", "cs after expiry", spi_cs_n, 1);
        chk(to_flag == 1'b1, "R5", "flag after expiry", to_flag, 1);
        // R10: flag clear
        to_clr = 1'b1;
        @(negedge clk);
        to_clr = 1'b0;
        chk(to_flag == 1'b0, "R10", "flag cleared", to_flag, 0);

        // R6: read colliding with timeout expiry
        c0 = cmd_cnt;
        do_read(24'h000100, 1'b0, "R2");
        chk(cmd_cnt - c0 == 1, "R4", "frame after release", cmd_cnt - c0, 1);
        repeat (TO - 1) @(negedge clk);
        c0 = cmd_cnt;
        do_read(24'h000101, 1'b0, "R6");
        chk(cmd_cnt - c0 == 1, "R6", "fresh frame on collision", cmd_cnt - c0, 1);
        chk(last_addr == 24'h000101, "R6", "collision address", last_addr, 24'h000101);
        chk(to_flag == 1'b1, "R6", "flag on collision", to_flag, 1);
        clear_flag();

        // R3: one cycle before expiry the frame continues
        do_read(24'h000200, 1'b0, "R4");
        repeat (TO - 2) @(negedge clk);
        c0 = cmd_cnt;
        do_read(24'h000201, 1'b0, "R3");
        chk(cmd_cnt == c0, "R3", "continued before expiry", cmd_cnt - c0, 0);
        chk(to_flag == 1'b0, "R3", "no flag before expiry", to_flag, 0);

        // R8: range rejection with a 64 KiB size
        size_code = 5'd15;
        c0 = cmd_cnt;
        do_read(24'h012345, 1'b1, "R8");
        chk(cmd_cnt == c0, "R8", "no frame for bad address", cmd_cnt - c0, 0);
        do_read(24'h00FFFF, 1'b0, "R8");
        size_code = 5'd23;

        // R9: abort in flight
        repeat (40) @(negedge clk);
        fork
            do_read(24'h003000, 1'b1, "R9");
            begin
                repeat (30) @(negedge clk);
                abort_req = 1'b1;
                @(negedge clk);
                abort_req = 1'b0;
                chk(abort_busy == 1'b1, "R9", "abort busy", abort_busy, 1);
                chk(spi_cs_n == 1'b1, "R9", "cs released", spi_cs_n, 1);
                chk(mm_active == 1'b0, "R9", "mode left", mm_active, 0);
            end
        join
        repeat (30) @(negedge clk);
        chk(abort_busy == 1'b0, "R9", "abort completed", abort_busy, 0);
        do_read(24'h003000, 1'b1, "R9");
        pulse_mm();
        do_read(24'h003000, 1'b0, "R9");

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R2", "pending responses", sb_q.size(), 0);
        finish_run();
    end
endmodule